// File: doc/BRIEF.md
# Precedence-Arbitrated Up/Down Event Counter

This block counts rising edges on two event inputs, one counting up and one counting down. The count stays between zero and a preset value that the surrounding logic supplies. Work happens only on clock cycles where a single-cycle processing strobe is high. On each such cycle the block samples four requests: clear, load, up and down. A fixed priority settles requests that arrive together, and the counter is updated on the clock edge where the strobe is sampled.

Clear beats load, and both block the two event inputs. When both event inputs rise on the same strobe, up is taken. The exception is a count already at the preset: up has no effect there, so down is taken. Edge history for the event inputs is refreshed on every strobe, including strobes where counting is blocked or the block is disabled. As a result, an input that is still high when clear, load or disable releases is not counted again. Two flags report whether the counter is at the preset and whether it is at zero. Dropping the enable forces an idle zero state.

Top module: `prio_updown_counter`

## Requirements
- R1: After reset, `count_o` is 0, `at_zero_o` is 1 and `at_max_o` is 0 (for a nonzero preset). The edge history of both event inputs reads as 0.
- R2: While enabled, `count_o` changes only on a clock edge where `tick_i` is high.
- R3: On a strobe with `clear_i` high, the count becomes 0. `load_i` and both event inputs are ignored.
- R4: On a strobe with `load_i` high and `clear_i` low, the count becomes `preset_i`. Rising edges on `up_i` or `down_i` at that strobe are discarded.
- R5: An event input counts only when it is 1 at a strobe and was 0 at the previous strobe. A level held high causes no further counting. History is updated at every strobe, including blocked or disabled ones, so a level still high when clear, load or enable releases is not counted.
- R6: When `up_i` and `down_i` both rise at the same strobe and the count is below the preset, the count increments and the down edge is discarded.
- R7: When both event inputs rise at the same strobe and the count is at or above the preset, the up edge is ignored. The down edge decrements the count (for example 7 becomes 6 with preset 7).
- R8: The count never wraps. A down edge at 0 leaves it at 0. An up edge with the count at or above the preset leaves it unchanged.
- R9: `at_max_o` equals `enable_i` AND (count ≥ `preset_i`). `at_zero_o` is 1 exactly when `count_o` is 0.
- R10: While `enable_i` is low, `count_o` reads 0 in the same cycle, `at_zero_o` is 1 and `at_max_o` is 0. The stored count is cleared, so re-enabling starts from 0.
- R11: A strobe's effect appears on `count_o` right after the clock edge that samples it, with no added cycle of lag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Counter enable; low forces the idle zero state |
| tick_i | input | 1 | Processing-interval strobe, one cycle wide |
| preset_i | input | WIDTH | Upper limit of the count and value used by load |
| clear_i | input | 1 | Clear request (highest priority) |
| load_i | input | 1 | Load-preset request |
| up_i | input | 1 | Count-up event level |
| down_i | input | 1 | Count-down event level |
| count_o | output | WIDTH | Present count |
| at_max_o | output | 1 | Count at or above preset while enabled |
| at_zero_o | output | 1 | Count equal to zero |

## Verification
A corrupted stored count shows on `count_o` and on both flags in the cycle after the faulty strobe. The bench compares every cycle, so it is caught at once. A stale or wrongly updated edge history does not show until the next strobe with the affected input high. It then appears as an extra or missing step, for example a held level counted again after clear releases. A wrong tie rule only shows when both inputs rise together, so the stimulus provides such coincidences both below the preset and at it.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;
   typedef enum logic [2:0] {
      ACT_HOLD  = 3'd0,
      ACT_CLEAR = 3'd1,
      ACT_LOAD  = 3'd2,
      ACT_INC   = 3'd3,
      ACT_DEC   = 3'd4
   } ucnt_act_e;
endpackage

// File: rtl/ucnt_edge.sv
module ucnt_edge #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_i,
   input  logic [N-1:0] lvl_i,
   output logic [N-1:0] rise_o
);
   generate
      if (N < 1) begin : g_bad_n
         $error("ucnt_edge: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_bit
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      prev_q <= 1'b0;
            else if (tick_i) prev_q <= lvl_i[i];
         end
         assign rise_o[i] = tick_i & lvl_i[i] & ~prev_q;
      end
   endgenerate
endmodule

// File: rtl/ucnt_arb.sv
module ucnt_arb
   import ucnt_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clear_i,
   input  logic             load_i,
   input  logic             up_rise_i,
   input  logic             dn_rise_i,
   input  logic [WIDTH-1:0] cnt_i,
   input  logic [WIDTH-1:0] preset_i,
   output ucnt_act_e        act_o
);
   logic up_room, dn_room;
   assign up_room = (cnt_i < preset_i);
   assign dn_room = (cnt_i != '0);

   always_comb begin
      if (clear_i)                  act_o = ACT_CLEAR;
      else if (load_i)              act_o = ACT_LOAD;
      else if (up_rise_i && up_room) act_o = ACT_INC;
      else if (dn_rise_i && dn_room) act_o = ACT_DEC;
      else                          act_o = ACT_HOLD;
   end
endmodule

// File: rtl/ucnt_reg.sv
module ucnt_reg
   import ucnt_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable_i,
   input  logic             tick_i,
   input  ucnt_act_e        act_i,
   input  logic [WIDTH-1:0] preset_i,
   output logic [WIDTH-1:0] cnt_o
);
   logic [WIDTH-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!enable_i) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         case (act_i)
            ACT_CLEAR: cnt_q <= '0;
            ACT_LOAD:  cnt_q <= preset_i;
            ACT_INC:   cnt_q <= cnt_q + 1'b1;
            ACT_DEC:   cnt_q <= cnt_q - 1'b1;
            default:   cnt_q <= cnt_q;
         endcase
      end
   end
   assign cnt_o = cnt_q;

   a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_i && !tick_i) |=> $stable(cnt_q));
   a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |=> (cnt_q == '0));
   a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i == ACT_INC || act_i == ACT_DEC || act_i == ACT_HOLD)
      |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1 ||
           cnt_q + 1 == $past(cnt_q) || cnt_q == '0));
endmodule

// File: rtl/prio_updown_counter.sv
module prio_updown_counter
   import ucnt_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable_i,
   input  logic             tick_i,
   input  logic [WIDTH-1:0] preset_i,
   input  logic             clear_i,
   input  logic             load_i,
   input  logic             up_i,
   input  logic             down_i,
   output logic [WIDTH-1:0] count_o,
   output logic             at_max_o,
   output logic             at_zero_o
);
   localparam int NEV = 2;

   generate
      if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
         $error("prio_updown_counter: WIDTH out of range 1..32");
      end
   endgenerate

   logic [NEV-1:0]   rise;
   logic [WIDTH-1:0] cnt;
   ucnt_act_e        act;

   ucnt_edge #(.N(NEV)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .lvl_i  ({down_i, up_i}),
      .rise_o (rise)
   );

   ucnt_arb #(.WIDTH(WIDTH)) u_arb (
      .clear_i   (clear_i),
      .load_i    (load_i),
      .up_rise_i (rise[0]),
      .dn_rise_i (rise[1]),
      .cnt_i     (cnt),
      .preset_i  (preset_i),
      .act_o     (act)
   );

   ucnt_reg #(.WIDTH(WIDTH)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable_i (enable_i),
      .tick_i   (tick_i),
      .act_i    (act),
      .preset_i (preset_i),
      .cnt_o    (cnt)
   );

   assign count_o   = enable_i ? cnt : '0;
   assign at_max_o  = enable_i && (cnt >= preset_i);
   assign at_zero_o = (count_o == '0);

   a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_i && tick_i && clear_i) |=> (count_o == '0 || !enable_i));
   a_r4_load_preset: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_i && tick_i && !clear_i && load_i)
      |=> (!enable_i || cnt == $past(preset_i)));
   a_r10_idle_flags: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |-> (at_zero_o && !at_max_o));
endmodule

// File: tb/prio_updown_counter_test.sv
module prio_updown_counter_test;
   localparam int W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable_i = 1'b0, tick_i = 1'b0, clear_i = 1'b0, load_i = 1'b0;
   logic up_i = 1'b0, down_i = 1'b0;
   logic [W-1:0] preset_i = 4'd7;
   logic [W-1:0] count_o;
   logic at_max_o, at_zero_o;

   always #5 clk = ~clk;

   prio_updown_counter #(.WIDTH(W)) uut (
      .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .tick_i(tick_i),
      .preset_i(preset_i), .clear_i(clear_i), .load_i(load_i),
      .up_i(up_i), .down_i(down_i),
      .count_o(count_o), .at_max_o(at_max_o), .at_zero_o(at_zero_o));

   int n_cmp = 0, n_bad = 0;
   int m_cnt = 0;
   bit m_pu = 0, m_pd = 0;
   string m_tag = "R1";
   bit comparing = 0;

   task automatic check(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model: behavioural, updated at each rising edge
   always @(posedge clk) begin
      if (rst_n) begin
         bit ue, de;
         int p;
         p = int'(preset_i);
         ue = up_i && !m_pu;
         de = down_i && !m_pd;
         if (tick_i) begin
            m_pu = up_i;
            m_pd = down_i;
         end
         if (!enable_i) begin
            m_cnt = 0; m_tag = "R10";
         end else if (tick_i) begin
            if (clear_i) begin m_cnt = 0; m_tag = "R3"; end
            else if (load_i) begin m_cnt = p; m_tag = "R4"; end
            else if (ue && m_cnt < p) begin m_cnt++; m_tag = de ? "R6" : "R11"; end
            else if (de && m_cnt > 0) begin m_cnt--; m_tag = ue ? "R7" : "R5"; end
            else m_tag = (ue || de) ? "R8" : "R5";
         end else m_tag = "R2";
      end
   end

   always @(negedge clk) begin
      if (comparing) begin
         int ec;
         ec = enable_i ? m_cnt : 0;
         check(m_tag, int'(count_o), ec);
         check("R9", int'(at_zero_o), int'(ec == 0));
         check(enable_i ? "R9" : "R10", int'(at_max_o),
               int'(enable_i && m_cnt >= int'(preset_i)));
      end
   end

   task automatic step(bit t, bit c, bit l, bit u, bit d);
      @(negedge clk);
      #1;
      tick_i = t; clear_i = c; load_i = l; up_i = u; down_i = d;
   endtask

   initial begin
      #200000000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check("R1", int'(count_o), 0);
      check("R1", int'(at_zero_o), 1);
      check("R1", int'(at_max_o), 0);
      rst_n = 1'b1;
      enable_i = 1'b1;
      comparing = 1;
      // directed: count up through preset 7, saturation
      for (int i = 0; i < 9; i++) begin
         step(1, 0, 0, 1, 0);
         step(1, 0, 0, 0, 0);
      end
      // held up level: no further counting (R5)
      step(1, 0, 0, 0, 0);
      step(1, 1, 0, 0, 0);
      step(1, 0, 0, 1, 0);
      step(1, 0, 0, 1, 0);
      step(1, 0, 0, 1, 0);
      // up held through clear release: not counted (R5, R3)
      step(1, 1, 1, 1, 0);
      step(1, 0, 0, 1, 0);
      step(1, 0, 0, 0, 0);
      // simultaneous below preset (R6)
      step(1, 0, 0, 1, 1);
      step(1, 0, 0, 0, 0);
      // load to 7, then simultaneous at preset (R7)
      step(1, 0, 1, 0, 0);
      step(1, 0, 0, 1, 1);
      step(1, 0, 0, 0, 0);
      // down at zero saturates (R8)
      step(1, 1, 0, 0, 0);
      step(1, 0, 0, 0, 1);
      step(1, 0, 0, 0, 0);
      // inputs without strobe ignored (R2)
      step(0, 0, 0, 1, 0);
      step(0, 1, 0, 0, 0);
      step(0, 0, 0, 0, 0);
      // disable with held down; re-enable (R10)
      step(1, 0, 1, 0, 0);
      enable_i = 1'b0;
      step(1, 0, 0, 0, 1);
      step(1, 0, 0, 0, 1);
      enable_i = 1'b1;
      step(1, 0, 0, 0, 1);
      step(1, 0, 0, 0, 0);
      // random phase
      for (int i = 0; i < 6000; i++) begin
         bit t, c, l, u, d;
         t = ($urandom % 3) != 0;
         c = ($urandom % 20) == 0;
         l = ($urandom % 14) == 0;
         u = $urandom % 2;
         d = $urandom % 2;
         if (($urandom % 400) == 0) preset_i = W'($urandom);
         if (($urandom % 300) == 0) enable_i = ~enable_i;
         if (!enable_i && ($urandom % 8) == 0) enable_i = 1'b1;
         step(t, c, l, u, d);
      end
      step(0, 0, 0, 0, 0);
      @(negedge clk);
      comparing = 0;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule